// File: doc/BRIEF.md
# Host Command Dispatcher with Timestep Counters

This block sits between a host command link and the memories and compute engine of a spiking-network accelerator. Each command carries an 8-bit opcode, an address and a data word, and is taken over a valid/ready handshake. The dispatcher turns the opcode into a one-cycle strobe for one target: the spike-mask memory, the network-structure memory or the neuron-state memory for writes, or a read strobe toward the neuron-state memory. It can also launch one timestep on the engine and wait for the engine to report that the timestep is finished.

Two counters go with the execute handshake. The step counter counts finished timesteps. The cycle timer clears when a timestep is launched, counts clock cycles while it runs and holds its value once the engine reports completion, so the length of the last timestep can still be read afterward. Spike events that the engine sends back to the host pass through the block and leave it carrying the step count that was current when they arrived.

The control is a three-state machine. `S_IDLE` accepts commands (ready high). An execute opcode taken in `S_IDLE` moves to `S_LAUNCH`, which pulses the launch output for one cycle and always moves on to `S_RUN`. `S_RUN` holds ready low and returns to `S_IDLE` on the cycle the engine's done input is high. Every other command taken in `S_IDLE` leaves the state at `S_IDLE`.

Top module: `hcmd_dispatch`

## Requirements
- R1: After reset, cmd_ready is 1, all strobes and run_start are 0, step_count and step_cycles are 0 and op_error is 0.
- R2: A command accepted with opcode 0x01, 0x02 or 0x03 raises mask_we, net_we or state_we respectively for exactly one cycle, in the cycle after acceptance, with tgt_addr and tgt_data equal to the command's address and data.
- R3: A command accepted with opcode 0x04 raises state_re for one cycle in the cycle after acceptance with tgt_addr equal to the command's address, and raises no write strobe.
- R4: A command accepted with opcode 0xC8 raises run_start for exactly one cycle, in the cycle after acceptance, and cmd_ready stays 0 from that cycle until the cycle after run_done is seen in S_RUN.
- R5: While cmd_ready is 0 no command is taken and no strobe is raised; a command held valid through that time is taken once cmd_ready returns to 1.
- R6: step_count increases by exactly 1 for each run_done seen in S_RUN; run_done at any other time has no effect on it.
- R7: step_cycles becomes 0 on the cycle after run_start, then increases by 1 each cycle of S_RUN without run_done, and holds its value from the run_done cycle until the next launch; for done asserted N cycles after run_start is seen, it reads N-1.
- R8: A spike event with spk_in_valid high appears one cycle later on spk_out_valid with the same identifier and with spk_out_step equal to step_count in the cycle it was presented.
- R9: A command accepted with any opcode other than 0x01, 0x02, 0x03, 0x04 or 0xC8 raises no strobe and no launch, and sets op_error, which stays 1 until reset.
- R10: At most one of mask_we, net_we, state_we, state_re and run_start is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Dispatcher can take a command |
| cmd_op | input | 8 | Opcode |
| cmd_addr | input | AW | Target address |
| cmd_data | input | DW | Write data |
| mask_we | output | 1 | Spike-mask memory write strobe |
| net_we | output | 1 | Network-structure memory write strobe |
| state_we | output | 1 | Neuron-state memory write strobe |
| state_re | output | 1 | Neuron-state memory read strobe |
| tgt_addr | output | AW | Address for the strobed target |
| tgt_data | output | DW | Data for the strobed target |
| run_start | output | 1 | One-cycle timestep launch to the engine |
| run_done | input | 1 | Engine reports timestep finished |
| step_count | output | CW | Finished timesteps |
| step_cycles | output | TW | Cycle length of current or last timestep |
| op_error | output | 1 | Sticky unknown-opcode flag |
| spk_in_valid | input | 1 | Spike event from the engine |
| spk_in_id | input | NW | Spiking neuron identifier |
| spk_out_valid | output | 1 | Tagged spike event toward the host |
| spk_out_id | output | NW | Identifier of the tagged spike |
| spk_out_step | output | CW | Step tag of the spike |

## Verification
The bound checker watches, every cycle, that strobes are mutually exclusive, that the launch is a lone pulse with ready low, that the step counter only ever steps by one, that the error flag never clears, that the timer stays still while idle and that every spike comes out one cycle later. Whether each opcode reaches the right target with the right address and data, the exact timer value for a given timestep length, that a command held during a timestep is taken afterward and that a stray done is ignored can only be shown by the bench's directed and random command sequences.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
    localparam logic [7:0] OP_MASK_WR  = 8'h01;
    localparam logic [7:0] OP_NET_WR   = 8'h02;
    localparam logic [7:0] OP_STATE_WR = 8'h03;
    localparam logic [7:0] OP_STATE_RD = 8'h04;
    localparam logic [7:0] OP_EXEC     = 8'hC8;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LAUNCH = 2'd1,
        S_RUN    = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/hcmd_fsm.sv
module hcmd_fsm
    import hcmd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          run_done,
    output logic          cmd_ready,
    output logic          run_start,
    output logic          run_end,
    output logic          mask_we,
    output logic          net_we,
    output logic          state_we,
    output logic          state_re,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_data,
    output logic          op_error
);
    ctl_state_t state, state_nx;
    logic       accept;

    assign accept = cmd_valid && cmd_ready;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (accept && cmd_op == OP_EXEC) state_nx = S_LAUNCH;
            S_LAUNCH: state_nx = S_RUN;
            S_RUN:    if (run_done) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // state-decoded outputs
    always_comb begin
        cmd_ready = 1'b0;
        run_start = 1'b0;
        run_end   = 1'b0;
        unique case (state)
            S_IDLE:   cmd_ready = 1'b1;
            S_LAUNCH: run_start = 1'b1;
            S_RUN:    run_end   = run_done;
            default:  cmd_ready = 1'b0;
        endcase
    end

    // registered target strobes and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_we  <= 1'b0;
            net_we   <= 1'b0;
            state_we <= 1'b0;
            state_re <= 1'b0;
            tgt_addr <= '0;
            tgt_data <= '0;
            op_error <= 1'b0;
        end else begin
            mask_we  <= 1'b0;
            net_we   <= 1'b0;
            state_we <= 1'b0;
            state_re <= 1'b0;
            if (accept) begin
                tgt_addr <= cmd_addr;
                tgt_data <= cmd_data;
                case (cmd_op)
                    OP_MASK_WR:  mask_we  <= 1'b1;
                    OP_NET_WR:   net_we   <= 1'b1;
                    OP_STATE_WR: state_we <= 1'b1;
                    OP_STATE_RD: state_re <= 1'b1;
                    OP_EXEC:     ;
                    default:     op_error <= 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/hcmd_counters.sv
module hcmd_counters #(
    parameter int CW = 32,
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          finish,
    output logic [CW-1:0] step_count,
    output logic [TW-1:0] step_cycles
);
    localparam logic [CW-1:0] STEP_ONE = CW'(1);
    localparam logic [TW-1:0] TICK_ONE = TW'(1);

    logic running;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running     <= 1'b0;
            step_count  <= '0;
            step_cycles <= '0;
        end else begin
            if (start) begin
                running     <= 1'b1;
                step_cycles <= '0;
            end else if (finish) begin
                running    <= 1'b0;
                step_count <= step_count + STEP_ONE;
            end else if (running) begin
                step_cycles <= step_cycles + TICK_ONE;
            end
        end
    end
endmodule

// File: rtl/hcmd_tagger.sv
module hcmd_tagger #(
    parameter int NW = 17,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [NW-1:0] in_id,
    input  logic [CW-1:0] cur_step,
    output logic          out_valid,
    output logic [NW-1:0] out_id,
    output logic [CW-1:0] out_step
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_id    <= '0;
            out_step  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_id   <= in_id;
                out_step <= cur_step;
            end
        end
    end
endmodule

// File: rtl/hcmd_dispatch.sv
module hcmd_dispatch #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 32,
    parameter int TW = 32,
    parameter int NW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [7:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    output logic          mask_we,
    output logic          net_we,
    output logic          state_we,
    output logic          state_re,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_data,
    output logic          run_start,
    input  logic          run_done,
    output logic [CW-1:0] step_count,
    output logic [TW-1:0] step_cycles,
    output logic          op_error,
    input  logic          spk_in_valid,
    input  logic [NW-1:0] spk_in_id,
    output logic          spk_out_valid,
    output logic [NW-1:0] spk_out_id,
    output logic [CW-1:0] spk_out_step
);
    logic run_end;

    hcmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .run_done  (run_done),
        .cmd_ready (cmd_ready),
        .run_start (run_start),
        .run_end   (run_end),
        .mask_we   (mask_we),
        .net_we    (net_we),
        .state_we  (state_we),
        .state_re  (state_re),
        .tgt_addr  (tgt_addr),
        .tgt_data  (tgt_data),
        .op_error  (op_error)
    );

    hcmd_counters #(.CW(CW), .TW(TW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (run_start),
        .finish      (run_end),
        .step_count  (step_count),
        .step_cycles (step_cycles)
    );

    hcmd_tagger #(.NW(NW), .CW(CW)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (spk_in_valid),
        .in_id     (spk_in_id),
        .cur_step  (step_count),
        .out_valid (spk_out_valid),
        .out_id    (spk_out_id),
        .out_step  (spk_out_step)
    );
endmodule

// File: rtl/hcmd_dispatch_chk.sv
module hcmd_dispatch_chk #(
    parameter int CW = 32,
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          mask_we,
    input logic          net_we,
    input logic          state_we,
    input logic          state_re,
    input logic          run_start,
    input logic [CW-1:0] step_count,
    input logic [TW-1:0] step_cycles,
    input logic          op_error,
    input logic          spk_in_valid,
    input logic          spk_out_valid
);
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mask_we, net_we, state_we, state_re, run_start}));

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> !run_start);

    p_busy_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |-> !cmd_ready);

    p_step_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(step_count) |-> step_count == $past(step_count) + CW'(1));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_error |=> op_error);

    p_timer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid) |=> $stable(step_cycles));

    p_spk_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spk_in_valid |=> spk_out_valid);
endmodule

bind hcmd_dispatch hcmd_dispatch_chk #(.CW(CW), .TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .mask_we       (mask_we),
    .net_we        (net_we),
    .state_we      (state_we),
    .state_re      (state_re),
    .run_start     (run_start),
    .step_count    (step_count),
    .step_cycles   (step_cycles),
    .op_error      (op_error),
    .spk_in_valid  (spk_in_valid),
    .spk_out_valid (spk_out_valid)
);

// File: tb/hcmd_dispatch_test.sv
module hcmd_dispatch_test;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 32;
    localparam int TW = 32;
    localparam int NW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [7:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          mask_we, net_we, state_we, state_re;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;
    logic          run_start;
    logic          run_done = 1'b0;
    logic [CW-1:0] step_count;
    logic [TW-1:0] step_cycles;
    logic          op_error;
    logic          spk_in_valid = 1'b0;
    logic [NW-1:0] spk_in_id = '0;
    logic          spk_out_valid;
    logic [NW-1:0] spk_out_id;
    logic [CW-1:0] spk_out_step;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    longint exp_step = 0;
    bit  exp_err = 1'b0;

    always #5 clk = ~clk;

    hcmd_dispatch #(.AW(AW), .DW(DW), .CW(CW), .TW(TW), .NW(NW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .mask_we(mask_we), .net_we(net_we), .state_we(state_we), .state_re(state_re),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .run_start(run_start),
        .run_done(run_done), .step_count(step_count), .step_cycles(step_cycles),
        .op_error(op_error), .spk_in_valid(spk_in_valid), .spk_in_id(spk_in_id),
        .spk_out_valid(spk_out_valid), .spk_out_id(spk_out_id),
        .spk_out_step(spk_out_step)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected strobe vector {mask, net, state_we, state_re} for an opcode
    function automatic logic [3:0] exp_strobes(input logic [7:0] op);
        case (op)
            8'h01:   return 4'b1000;
            8'h02:   return 4'b0100;
            8'h03:   return 4'b0010;
            8'h04:   return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic bit is_known(input logic [7:0] op);
        return (op == 8'h01 || op == 8'h02 || op == 8'h03 || op == 8'h04 || op == 8'hC8);
    endfunction

    // non-execute command: accepted at the next edge, strobe checked after it
    task automatic send_simple(input logic [7:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [3:0] e;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        e = exp_strobes(op);
        if (!is_known(op)) exp_err = 1'b1;
        check({mask_we, net_we, state_we, state_re} == e,
              (op == 8'h04) ? "R3 read strobe" : (is_known(op) ? "R2 write strobe" : "R9 no strobe"),
              {mask_we, net_we, state_we, state_re}, e);
        check(run_start == 1'b0, "R9 no launch", run_start, 0);
        if (e != 4'b0000) begin
            check(tgt_addr == a, "R2 target address", tgt_addr, a);
            if (op != 8'h04) check(tgt_data == d, "R2 target data", tgt_data, d);
        end
        check(op_error == exp_err, "R9 sticky error", op_error, exp_err);
        @(negedge clk);
        check({mask_we, net_we, state_we, state_re} == 4'b0000, "R2 strobe one cycle",
              {mask_we, net_we, state_we, state_re}, 0);
    endtask

    // execute with done raised n cycles after launch is seen (n >= 1)
    task automatic send_exec(input int n, input bit hold_mask, input logic [AW-1:0] ha);
        cmd_valid = 1'b1; cmd_op = 8'hC8; cmd_addr = '0; cmd_data = '0;
        @(negedge clk);
        check(run_start == 1'b1, "R4 launch pulse", run_start, 1);
        check(cmd_ready == 1'b0, "R4 ready low", cmd_ready, 0);
        if (hold_mask) begin
            cmd_op = 8'h01; cmd_addr = ha; cmd_data = 32'h5A5A_0000 | 32'(ha);
        end else cmd_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(run_start == 1'b0, "R4 launch single cycle", run_start, 0);
            check(cmd_ready == 1'b0, "R5 ready low in run", cmd_ready, 0);
            check(mask_we == 1'b0, "R5 no strobe while busy", mask_we, 0);
        end
        run_done = 1'b1;
        @(negedge clk);
        run_done = 1'b0;
        exp_step++;
        check(cmd_ready == 1'b1, "R4 ready back", cmd_ready, 1);
        check(step_count == CW'(exp_step), "R6 step count", step_count, exp_step);
        check(step_cycles == TW'(n - 1), "R7 timer length", step_cycles, n - 1);
        if (hold_mask) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            check(mask_we == 1'b1, "R5 held command taken", mask_we, 1);
            check(tgt_addr == ha, "R5 held address", tgt_addr, ha);
        end
        @(negedge clk);
        check(step_cycles == TW'(n - 1), "R7 timer frozen", step_cycles, n - 1);
    endtask

    task automatic send_spike(input logic [NW-1:0] id);
        longint tag;
        tag = longint'(step_count);
        spk_in_valid = 1'b1; spk_in_id = id;
        @(negedge clk);
        spk_in_valid = 1'b0;
        check(spk_out_valid == 1'b1, "R8 spike valid", spk_out_valid, 1);
        check(spk_out_id == id, "R8 spike id", spk_out_id, id);
        check(spk_out_step == CW'(tag), "R8 spike tag", spk_out_step, tag);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
        check({mask_we, net_we, state_we, state_re, run_start} == 5'b0, "R1 strobes",
              {mask_we, net_we, state_we, state_re, run_start}, 0);
        check(step_count == '0 && step_cycles == '0, "R1 counters", step_count, 0);
        check(op_error == 1'b0, "R1 error", op_error, 0);

        // directed
        send_simple(8'h01, 16'h0010, 32'hDEAD_0001);
        send_simple(8'h02, 16'hFFFF, 32'hFFFF_FFFF);
        send_simple(8'h03, 16'h0000, 32'h0000_0000);
        send_simple(8'h04, 16'h1234, 32'h0);
        send_exec(1, 1'b0, '0);
        send_exec(7, 1'b1, 16'h0042);
        // R6: stray done while idle
        run_done = 1'b1;
        @(negedge clk);
        run_done = 1'b0;
        @(negedge clk);
        check(step_count == CW'(exp_step), "R6 stray done ignored", step_count, exp_step);
        send_spike(17'h1_0005);
        send_simple(8'h00, 16'h0001, 32'h1);
        send_simple(8'hFF, 16'h0002, 32'h2);
        send_simple(8'h01, 16'h0003, 32'h3);

        // random
        for (int k = 0; k < 60; k++) begin
            int sel;
            sel = $urandom_range(0, 6);
            case (sel)
                0: send_simple(8'h01, AW'($urandom), $urandom);
                1: send_simple(8'h02, AW'($urandom), $urandom);
                2: send_simple(8'h03, AW'($urandom), $urandom);
                3: send_simple(8'h04, AW'($urandom), $urandom);
                4: send_exec($urandom_range(1, 20), 1'($urandom), AW'($urandom));
                5: send_simple(8'h10 + 8'($urandom_range(0, 15)), AW'($urandom), $urandom);
                default: send_spike(NW'($urandom));
            endcase
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule